// File: doc/BRIEF.md
# Key-Sequence Register Write Lock

This block protects a window of configuration registers against accidental writes. It watches a byte-wide register write bus made of a strobe, an address and data. It keeps a single lock flag. That flag can only be changed by writing two fixed key bytes to a control address and then one more write to the same address. Bit 6 of that third write gives the new lock value.

While the flag is set, writes aimed at the protected window still complete on the bus without any error indication. The block withholds the write-enable qualifier, so the protected registers keep their contents.

A one-way configuration input lets the system make the lock permanent. With it asserted, the flag can still be set, but once set it can no longer be cleared. Integrators should tie this input high unless repeated reconfiguration is wanted.

Top module: `key_write_lock`

## Requirements
- R1: After reset `lock` is 0 and no key byte has been seen.
- R2: Writing 0x46 and then 0x57 to the control address (`CTRL_ADDR`, default 0) arms the block. The next control write sets `lock` to its data bit 6, visible on the cycle after that write.
- R3: A control write with any value other than the expected key byte returns the detector to idle. A write of 0x46 in any non-armed state counts as a fresh first key byte.
- R4: A write to any address other than the control address cancels a partly entered or armed key sequence.
- R5: The armed state is used up by exactly one control write, whether or not `lock` changes. That write is never taken as a key byte.
- R6: `lock` keeps its value across any number of writes that are not armed control writes.
- R7: When `one_way` is 1 at the armed write and `lock` is 1, `lock` stays 1 whatever the data.
- R8: When `one_way` is 0, any number of lock and unlock sessions succeed, each with its own key sequence.
- R9: In the same cycle, `prot_wr_en` equals `wr_en` AND (`PROT_BASE` <= `wr_addr` < `PROT_BASE+PROT_CNT`, default 4 to 11) AND NOT `lock`. Locked writes are dropped with no error signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| one_way | input | 1 | 1: lock cannot be cleared once set |
| lock | output | 1 | Current lock flag |
| prot_wr_en | output | 1 | Write enable for the protected window |

## Verification
A detector stuck in the wrong state shows up on the write after the key bytes. `lock` then either fails to follow bit 6 or moves on a write that should have been inert, one cycle after that write. A wrong lock flag shows at once in `prot_wr_en` for any write to the protected window. The sweeps push every byte value through each key position and through the armed write, so a wrong comparison constant or a wrong bit position appears within four bus writes.

// File: rtl/klock_pkg.sv
package klock_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'h57;
  localparam int unsigned LOCK_POS  = 6;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  // Next detector state for one bus cycle.
  function automatic key_state_e key_step(key_state_e cur, logic ctrl_wr,
                                          logic other_wr, logic [7:0] d);
    key_state_e nxt;
    nxt = cur;
    if (ctrl_wr) begin
      if (cur == KS_ARMED)                      nxt = KS_IDLE;
      else if (d == KEY_FIRST)                  nxt = KS_HALF;
      else if (cur == KS_HALF && d == KEY_SECOND) nxt = KS_ARMED;
      else                                      nxt = KS_IDLE;
    end else if (other_wr) begin
      nxt = KS_IDLE;
    end
    return nxt;
  endfunction

  // Lock value after an armed control write.
  function automatic logic lock_step(logic cur, logic req, logic one_way);
    return (one_way && cur) ? 1'b1 : req;
  endfunction

endpackage

// File: rtl/klock_seq.sv
module klock_seq
  import klock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       other_wr,
  input  logic [7:0] data,
  output logic       armed,
  output logic       consume
);

  key_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= key_step(state_q, ctrl_wr, other_wr, data);
  end

  assign armed   = (state_q == KS_ARMED);
  assign consume = ctrl_wr && armed;

  // R2: armed only right after the second key byte following the first
  assert_arm_after_keys_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(ctrl_wr && data == KEY_SECOND && state_q == KS_HALF));

  // R5: one control write uses up the armed state
  assert_armed_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(consume) |-> !armed);

  // R4: foreign writes cancel any progress
  assert_foreign_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(other_wr) |-> state_q == KS_IDLE);

endmodule

// File: rtl/klock_bit.sv
module klock_bit
  import klock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic req_bit,
  input  logic one_way,
  output logic lock
);

  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b0;
    else if (commit) lock_q <= lock_step(lock_q, req_bit, one_way);
  end

  assign lock = lock_q;

  // R6: lock moves only on a committed armed write
  assert_lock_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(lock_q));

  // R7: one-way mode never lets a set lock fall
  assert_one_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q && one_way) |-> lock_q);

endmodule

// File: rtl/klock_window.sv
module klock_window #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned PROT_BASE = 4,
  parameter int unsigned PROT_CNT  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(PROT_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(PROT_BASE + PROT_CNT);

  generate
    if (PROT_CNT == 0) begin : g_empty
      assign hit = 1'b0;
    end else begin : g_range
      logic [ADDR_W:0] ext;
      assign ext = {1'b0, addr};
      assign hit = (ext >= LO) && (ext < HI);
    end
  endgenerate

endmodule

// File: rtl/key_write_lock.sv
module key_write_lock
  import klock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned PROT_BASE = 4,
  parameter int unsigned PROT_CNT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              one_way,
  output logic              lock,
  output logic              prot_wr_en
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_wr, other_wr, armed, consume, win_hit;

  assign ctrl_wr  = wr_en && (wr_addr == CTRL_A);
  assign other_wr = wr_en && (wr_addr != CTRL_A);

  klock_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .other_wr(other_wr),
    .data(wr_data), .armed(armed), .consume(consume)
  );

  klock_bit u_bit (
    .clk(clk), .rst_n(rst_n), .commit(consume),
    .req_bit(wr_data[LOCK_POS]), .one_way(one_way), .lock(lock)
  );

  klock_window #(.ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_CNT(PROT_CNT)) u_win (
    .addr(wr_addr), .hit(win_hit)
  );

  assign prot_wr_en = wr_en && win_hit && !lock;

  // R9: a locked block never passes a protected write
  assert_locked_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !prot_wr_en);

  // R2: lock follows data bit 6 after an armed write when not frozen
  assert_lock_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(consume && !(one_way && lock)) |-> lock == $past(wr_data[LOCK_POS]));

endmodule

// File: tb/key_write_lock_test.sv
module key_write_lock_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       one_way = 1'b0;
  logic       lock, prot_wr_en;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  key_write_lock uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .one_way(one_way), .lock(lock), .prot_wr_en(prot_wr_en)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic key();
    wr(4'd0, 8'h46); wr(4'd0, 8'h57);
  endtask

  function automatic int win_exp(int a, logic lk);
    return (a >= 4 && a < 12 && !lk) ? 1 : 0;
  endfunction

  initial begin
    do_reset();
    check("R1 lock after reset", lock, 0);
    // R1: no key progress after reset: a lone 0x57 then armed-looking write does nothing
    wr(4'd0, 8'h57); wr(4'd0, 8'h40);
    check("R1 idle detector", lock, 0);

    // R3 sweep of first key byte
    for (int b = 0; b < 256; b++) begin
      do_reset();
      wr(4'd0, 8'(b)); wr(4'd0, 8'h57); wr(4'd0, 8'h40);
      check("R3 first byte sweep", lock, (b == 8'h46) ? 1 : 0);
    end
    // R3 sweep of second key byte
    for (int b = 0; b < 256; b++) begin
      do_reset();
      wr(4'd0, 8'h46); wr(4'd0, 8'(b)); wr(4'd0, 8'h40);
      check("R3 second byte sweep", lock, (b == 8'h57) ? 1 : 0);
    end
    // R3: repeated first byte restarts
    do_reset();
    wr(4'd0, 8'h46); wr(4'd0, 8'h46); wr(4'd0, 8'h57); wr(4'd0, 8'h40);
    check("R3 restart on 0x46", lock, 1);

    // R2 / R8 sweep of armed data, from both lock values, one_way=0
    one_way = 0;
    for (int d = 0; d < 256; d++) begin
      do_reset();
      key(); wr(4'd0, 8'(d));
      check("R2 armed write from clear", lock, (d >> 6) & 1);
      do_reset();
      key(); wr(4'd0, 8'h40); key(); wr(4'd0, 8'(d));
      check("R8 armed write from set", lock, (d >> 6) & 1);
    end

    // R8 many sessions
    do_reset();
    for (int s = 0; s < 6; s++) begin
      key(); wr(4'd0, (s % 2 == 0) ? 8'h40 : 8'h00);
      check("R8 repeated session", lock, (s % 2 == 0) ? 1 : 0);
    end

    // R7 one-way sweep
    one_way = 1;
    do_reset();
    key(); wr(4'd0, 8'h00);
    check("R7 clear while clear", lock, 0);
    key(); wr(4'd0, 8'h40);
    check("R7 set allowed", lock, 1);
    for (int d = 0; d < 256; d++) begin
      key(); wr(4'd0, 8'(d));
      check("R7 frozen lock", lock, 1);
    end
    one_way = 0;

    // R5 consumption
    do_reset();
    key(); wr(4'd0, 8'h00);
    wr(4'd0, 8'h40);
    check("R5 no second armed write", lock, 0);
    do_reset();
    key(); wr(4'd0, 8'h46);
    check("R5 armed 0x46 sets lock", lock, 1);
    wr(4'd0, 8'h57); wr(4'd0, 8'h00);
    check("R5 0x46 not taken as key", lock, 1);

    // R4 interruption
    do_reset();
    wr(4'd0, 8'h46); wr(4'd5, 8'h00); wr(4'd0, 8'h57); wr(4'd0, 8'h40);
    check("R4 write between keys", lock, 0);
    do_reset();
    key(); wr(4'd13, 8'h40); wr(4'd0, 8'h40);
    check("R4 write while armed", lock, 0);

    // R6 persistence
    do_reset();
    key(); wr(4'd0, 8'h40);
    for (int i = 0; i < 16; i++) wr(4'(i), 8'h00);
    check("R6 lock persists", lock, 1);

    // R9 address sweep, locked then unlocked
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = 8'hAA;
      #1 check("R9 locked window", prot_wr_en, win_exp(a, 1'b1));
      @(negedge clk); wr_en = 0;
      #1 check("R9 no strobe", prot_wr_en, 0);
    end
    check("R6 lock after sweep", lock, 1);
    key(); wr(4'd0, 8'h00);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = 8'h55;
      #1 check("R9 open window", prot_wr_en, win_exp(a, 1'b0));
      @(negedge clk); wr_en = 0;
    end
    check("R6 open after sweep", lock, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule